// File: doc/BRIEF.md
# Display Frame Interrupt Controller

This block sits beside the frame pipeline of a display controller and turns pipeline markers into interrupt status. Four single-cycle pulses mark frame boundaries: the first and the last word of a frame as it is fetched from memory, and the first and the last word as it is driven to the panel. The panel-side pulses arrive some pipeline latency after the fetch-side ones. Four more pulses report fault conditions: an error and an underrun for the background plane, and the same pair for the graphic-window plane.

A control register picks one frame boundary to record. One bit chooses the stage (fetch or panel) and another chooses the boundary (start or end). Every source has a sticky status flag, which software clears by writing one to it. A per-source enable mask decides which flags drive the single registered interrupt request. A masked flag still sets and can still be read.

Software reaches the three registers through a plain write strobe, an address and a combinational read-data bus.

Top module: `frame_irq_ctrl`

## Requirements
- R1: After reset, the control, enable and status registers all read 0 and `irq` is 0.
- R2: The control register is at address 0. Bit 0 is the boundary select (0 = end of frame, 1 = start of frame) and bit 2 is the stage select (0 = memory fetch, 1 = panel output). Bit 1 and bits 31..3 always read 0.
- R3: The enable register is at address 1. Bits 5..0 are writable and bits 31..6 always read 0. Status and enable share one bit map: bit 0 start-of-frame, bit 1 end-of-frame, bit 2 background error, bit 3 background underrun, bit 4 window error, bit 5 window underrun.
- R4: With stage 0 and boundary 0, a last-fetched pulse sets status bit 1, and no other frame pulse sets a frame flag.
- R5: With stage 0 and boundary 1, a first-fetched pulse sets status bit 0, and no other frame pulse sets a frame flag.
- R6: With stage 1 and boundary 0, a last-output pulse sets status bit 1, and no other frame pulse sets a frame flag.
- R7: With stage 1 and boundary 1, a first-output pulse sets status bit 0, and no other frame pulse sets a frame flag.
- R8: The four fault pulses set status bits 2 to 5 whatever the select bits hold.
- R9: The status register is at address 2. Its flags stay set until a write to address 2 has a 1 in the matching bit. Bits written as 0 are left unchanged.
- R10: If a set pulse and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R11: `irq` is registered. It goes high in the cycle after a status flag whose enable bit is 1 becomes set, and it goes low in the cycle after no enabled flag remains set.
- R12: A flag whose enable bit is 0 still sets in status but does not raise `irq`.
- R13: Writing the select bits never sets a flag by itself. A frame pulse in the same cycle as a control write is judged by the old select bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 enable, 2 status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| fetch_first | input | 1 | First word of the frame fetched from memory |
| fetch_last | input | 1 | Last word of the frame fetched from memory |
| emit_first | input | 1 | First word of the frame driven to the panel |
| emit_last | input | 1 | Last word of the frame driven to the panel |
| bg_err | input | 1 | Background plane error pulse |
| bg_udr | input | 1 | Background plane underrun pulse |
| win_err | input | 1 | Graphic-window plane error pulse |
| win_udr | input | 1 | Graphic-window plane underrun pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume two things about the inputs. Every event input is a one-cycle pulse synchronous to `clk`. The fetch-stage pulse and the panel-stage pulse of one frame are separate events, so they may fall in different cycles. The bench drives each pulse for exactly one cycle between falling edges. It spaces the fetch-side and panel-side markers apart, so each one lands in status on its own. It also drives a control write in the same cycle as a frame pulse, which tests that the pulse is judged by the old select bits.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;
  localparam int ADDR_W  = 2;
  localparam int NSRC    = 6;
  localparam int NFAULT  = 4;

  localparam int SRC_SOF  = 0;
  localparam int SRC_EOF  = 1;
  localparam int SRC_FLT0 = 2;

  localparam int CTL_EDGE  = 0;
  localparam int CTL_STAGE = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 2'd0,
    RA_MASK = 2'd1,
    RA_STAT = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic first;
    logic last;
  } bound_pair_t;
endpackage

// File: rtl/frame_evt_sel.sv
module frame_evt_sel
  import frame_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stage_sel,
  input  logic              edge_sel,
  input  bound_pair_t       fetch_b,
  input  bound_pair_t       emit_b,
  input  logic [NFAULT-1:0] fault,
  output logic [NSRC-1:0]   set_vec
);
  bound_pair_t chosen;
  logic        any_frame;

  always_comb begin
    chosen = stage_sel ? emit_b : fetch_b;
  end

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_SOF]  = edge_sel & chosen.first;
    set_vec[SRC_EOF]  = ~edge_sel & chosen.last;
    for (int i = 0; i < NFAULT; i++) begin
      set_vec[SRC_FLT0 + i] = fault[i];
    end
  end

  assign any_frame = fetch_b.first | fetch_b.last | emit_b.first | emit_b.last;

  // Only one frame boundary can be selected, so at most one frame flag sets per cycle.
  assert_frame_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec[SRC_EOF:SRC_SOF]));

  // A frame flag can only come from a frame marker pulse.
  assert_no_spurious_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !any_frame |-> (set_vec[SRC_EOF:SRC_SOF] == 2'b00));
endmodule

// File: rtl/frame_irq_cfg.sv
module frame_irq_cfg
  import frame_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NSRC-1:0]   status_i,
  output logic [REG_W-1:0]  rdata,
  output logic              stage_sel,
  output logic              edge_sel,
  output logic [NSRC-1:0]   en_mask,
  output logic [NSRC-1:0]   clr_vec
);
  logic            ctrl_ce, mask_ce;
  logic            stage_q, stage_d, edge_q, edge_d;
  logic [NSRC-1:0] mask_q, mask_d;
  logic            unused_wbits;

  assign unused_wbits = ^wdata[REG_W-1:NSRC];

  always_comb begin
    ctrl_ce = wr_en && (addr == RA_CTRL);
    mask_ce = wr_en && (addr == RA_MASK);
    stage_d = ctrl_ce ? wdata[CTL_STAGE] : stage_q;
    edge_d  = ctrl_ce ? wdata[CTL_EDGE]  : edge_q;
    mask_d  = mask_ce ? wdata[NSRC-1:0]  : mask_q;
    clr_vec = (wr_en && (addr == RA_STAT)) ? wdata[NSRC-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      edge_q  <= 1'b0;
      mask_q  <= '0;
    end else begin
      stage_q <= stage_d;
      edge_q  <= edge_d;
      mask_q  <= mask_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL: begin
        rdata[CTL_STAGE] = stage_q;
        rdata[CTL_EDGE]  = edge_q;
      end
      RA_MASK: rdata[NSRC-1:0] = mask_q;
      RA_STAT: rdata[NSRC-1:0] = status_i;
      default: rdata = '0;
    endcase
  end

  assign stage_sel = stage_q;
  assign edge_sel  = edge_q;
  assign en_mask   = mask_q;

  // Reserved control bits never read back as 1.
  assert_ctrl_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == RA_CTRL) |-> (rdata[1] == 1'b0 && rdata[REG_W-1:3] == '0));

  // Enable bits above the source count never read back as 1.
  assert_mask_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == RA_MASK) |-> (rdata[REG_W-1:NSRC] == '0));
endmodule

// File: rtl/frame_irq_status.sv
module frame_irq_status
  import frame_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] status_o
);
  logic [NSRC-1:0] st_q, st_d;

  always_comb begin
    st_d = (st_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status_o = st_q;

  // A set flag that is not cleared stays set.
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(st_q & ~clr_i)) == $past(st_q & ~clr_i)));

  // A set pulse beats a clear that arrives in the same cycle.
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & clr_i)) |=> ((st_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/frame_irq_req.sv
module frame_irq_req
  import frame_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] status_i,
  input  logic [NSRC-1:0] en_i,
  output logic            irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = |(status_i & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // With every source masked, the request is low one cycle later.
  assert_masked_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> !irq_o);

  // The request never rises without some status flag set in the cycle before.
  assert_req_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(status_i != '0));
endmodule

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl
  import frame_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              fetch_first,
  input  logic              fetch_last,
  input  logic              emit_first,
  input  logic              emit_last,
  input  logic              bg_err,
  input  logic              bg_udr,
  input  logic              win_err,
  input  logic              win_udr,
  output logic              irq
);
  logic              stage_sel, edge_sel;
  logic [NSRC-1:0]   en_mask, clr_vec, set_vec, status;
  bound_pair_t       fetch_b, emit_b;
  logic [NFAULT-1:0] fault;

  assign fetch_b = '{first: fetch_first, last: fetch_last};
  assign emit_b  = '{first: emit_first,  last: emit_last};
  assign fault   = {win_udr, win_err, bg_udr, bg_err};

  frame_irq_cfg #(.REG_W(REG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .status_i  (status),
    .rdata     (reg_rdata),
    .stage_sel (stage_sel),
    .edge_sel  (edge_sel),
    .en_mask   (en_mask),
    .clr_vec   (clr_vec)
  );

  frame_evt_sel u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .stage_sel (stage_sel),
    .edge_sel  (edge_sel),
    .fetch_b   (fetch_b),
    .emit_b    (emit_b),
    .fault     (fault),
    .set_vec   (set_vec)
  );

  frame_irq_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .status_o (status)
  );

  frame_irq_req u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status),
    .en_i     (en_mask),
    .irq_o    (irq)
  );

  // Fault pulses reach status whatever the select bits hold.
  assert_fault_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bg_err |=> status[SRC_FLT0]);
endmodule

// File: tb/sim_frame_irq_ctrl.sv
module sim_frame_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_EN = 2'd1, A_ST = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  ev = '0;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fetch_first(ev[0]), .fetch_last(ev[1]), .emit_first(ev[2]), .emit_last(ev[3]),
    .bg_err(ev[4]), .bg_udr(ev[5]), .win_err(ev[6]), .win_udr(ev[7]),
    .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(logic [7:0] p);
    @(negedge clk);
    ev = p;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_EN, d);   check("R1 enable", d, 0);
    rd(A_ST, d);   check("R1 status", d, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); check("R2 ctrl readback", d, 32'h5);
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d);   check("R3 enable readback", d, 32'h3F);
    wr(A_EN, 32'h0);
    rd(A_EN, d);   check("R3 enable cleared", d, 32'h0);
  endtask

  task automatic t_mode(bit stage, bit bnd, string req);
    logic [31:0] d;
    wr(A_CTRL, {29'd0, stage, 1'b0, bnd});
    for (int k = 0; k < 4; k++) begin
      logic [31:0] exp;
      wr(A_ST, 32'h3F);
      pulse(8'(1 << k));
      exp = (((k >> 1) == int'(stage)) && ((k & 1) == (bnd ? 0 : 1))) ?
            (bnd ? 32'h1 : 32'h2) : 32'h0;
      rd(A_ST, d);
      check(req, d, exp);
    end
  endtask

  task automatic t_faults();
    logic [31:0] d;
    for (int s = 0; s < 2; s++) begin
      wr(A_CTRL, s ? 32'h5 : 32'h0);
      for (int k = 0; k < 4; k++) begin
        wr(A_ST, 32'h3F);
        pulse(8'(16 << k));
        rd(A_ST, d);
        check("R8 fault flag", d, 32'(4 << k));
      end
    end
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(A_ST, 32'h3F);
    pulse(8'hF0);
    wr(A_ST, 32'h0);
    rd(A_ST, d); check("R9 write zero keeps", d, 32'h3C);
    wr(A_ST, 32'h4);
    rd(A_ST, d); check("R9 write one clears", d, 32'h38);
    wr(A_ST, 32'h3F);
    rd(A_ST, d); check("R9 clear all", d, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    wr(A_CTRL, 32'h0);
    wr(A_ST, 32'h3F);
    pulse(8'h02);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h2; ev = 8'h02;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; ev = '0;
    rd(A_ST, d); check("R10 set beats clear", d, 32'h2);
  endtask

  task automatic t_irq();
    wr(A_ST, 32'h3F);
    wr(A_EN, 32'h4);
    pulse(8'h10);
    check("R11 irq one cycle later", {31'd0, irq}, 0);
    @(negedge clk);
    check("R11 irq raised", {31'd0, irq}, 1);
    wr(A_ST, 32'h4);
    check("R11 irq still registered", {31'd0, irq}, 1);
    @(negedge clk);
    check("R11 irq dropped", {31'd0, irq}, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_EN, 32'h3B);
    wr(A_ST, 32'h3F);
    pulse(8'h10);
    @(negedge clk); @(negedge clk);
    check("R12 masked irq low", {31'd0, irq}, 0);
    rd(A_ST, d); check("R12 masked status set", d, 32'h4);
    wr(A_EN, 32'h4);
    @(negedge clk);
    check("R12 unmask raises irq", {31'd0, irq}, 1);
    wr(A_EN, 32'h0);
    wr(A_ST, 32'h3F);
  endtask

  task automatic t_sel_change();
    logic [31:0] d;
    wr(A_CTRL, 32'h0);
    wr(A_ST, 32'h3F);
    for (int v = 0; v < 8; v++) wr(A_CTRL, 32'(v));
    rd(A_ST, d); check("R13 select writes set nothing", d, 32'h0);
    wr(A_CTRL, 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'h1; ev = 8'h02;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; ev = '0;
    rd(A_ST, d); check("R13 old select used", d, 32'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    wr(A_EN, 32'h0);
    t_mode(1'b0, 1'b0, "R4 fetch/end");
    t_mode(1'b0, 1'b1, "R5 fetch/start");
    t_mode(1'b1, 1'b0, "R6 panel/end");
    t_mode(1'b1, 1'b1, "R7 panel/start");
    t_faults();
    t_w1c();
    t_set_wins();
    t_irq();
    t_mask();
    t_sel_change();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule